// File: doc/BRIEF.md
# Fused Multiply-Add Doubleword Unit

This execution unit multiplies two 64-bit integer operands and adds a third at full 128-bit precision, then returns one 64-bit doubleword chosen by the instruction. Three operations exist: the upper doubleword in signed form, the upper doubleword in unsigned form, and the lower doubleword. The addend is extended to 128 bits according to the signedness of the operation before it is summed with the complete product, so a carry or borrow out of the low half always reaches the upper half.

The unit takes a 32-bit instruction word alongside the operand values and decodes the opcode and form-select fields itself. Encodings it does not recognise are flagged as illegal and carry no result. The destination and source register numbers from the instruction come back out with the result for the writeback stage.

Both edges are valid/ready streams. An operation is taken when `in_valid` and `in_ready` are high at a clock edge, and `in_ready` is high only while the unit is idle. The multiply is iterative and consumes `STEP_BITS` bits of B per cycle. A finished response waits with `out_valid` high and all output fields frozen until `out_ready` is high at an edge. The unit takes no new operation in the cycle in which its response drains.

Top module: `fmadd_dw_unit`

## Requirements
- R1: The unit decodes the instruction word with bit 0 as the least significant bit. The primary opcode is in_insn[31:26] and must equal 4. The extended field is in_insn[5:1]: value 0x18 selects a high form and 0x19 selects the low form. In_insn[0] picks the unsigned high form when it is 1 and the signed high form when it is 0. The low form ignores in_insn[0].
- R2: The signed high form returns bits [127:64] of the signed product A×B plus C sign-extended to 128 bits.
- R3: The unsigned high form returns bits [127:64] of the unsigned product A×B plus C zero-extended to 128 bits.
- R4: The low form returns bits [63:0] of A×B+C.
- R5: A carry or borrow out of bit 63 of the 128-bit sum is reflected in the high result, including the extremes: most negative times most negative, and all-ones operands.
- R6: Any other encoding gives a response with out_illegal=1 and out_result=0. Legal responses have out_illegal=0.
- R7: out_rd, out_ra, out_rb and out_rc carry in_insn[25:21], [20:16], [15:11] and [10:6] of the accepted instruction.
- R8: in_ready is high exactly while no operation is held. An operation is accepted at an edge where in_valid and in_ready are both high.
- R9: For a legal operation, out_valid rises at the XLEN/STEP_BITS-th edge after the accepting edge (the 8th edge with the default parameters). For an illegal one, it rises at the accepting edge itself.
- R10: While out_valid is high and out_ready is low, every output field stays stable. After an edge with out_valid and out_ready both high, out_valid is low and in_ready is high.
- R11: After reset, in_ready=1 and out_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit idle, operation can be taken |
| in_insn | input | 32 | Instruction word |
| in_a | input | XLEN | Multiplicand A |
| in_b | input | XLEN | Multiplier B |
| in_c | input | XLEN | Addend C |
| out_valid | output | 1 | Response held |
| out_ready | input | 1 | Consumer takes the response |
| out_result | output | XLEN | Selected doubleword, zero when illegal |
| out_illegal | output | 1 | Encoding not recognised, no write |
| out_rd | output | 5 | Destination register number |
| out_ra | output | 5 | Source A register number |
| out_rb | output | 5 | Source B register number |
| out_rc | output | 5 | Source C register number |

## Verification
The functions that meet in one cycle are the drain of a finished response and the offer of the next operation. The bench keeps in_valid high for a new operation while the previous result is still held, and it gates out_ready with a pseudo-random pattern. This makes the handshake on the output and the pending offer on the input fall on the same edge. The reference model predicts that the offer is refused on that edge and taken one cycle later, and in_ready, out_valid and every output field are compared against that prediction on each clock.

// File: rtl/fmadd_pkg.sv
package fmadd_pkg;
  localparam logic [5:0] PRIMARY_OP = 6'd4;
  localparam logic [4:0] XO_HIGH    = 5'h18;
  localparam logic [4:0] XO_LOW     = 5'h19;

  typedef enum logic [1:0] {
    OP_HI_S = 2'd0,
    OP_HI_U = 2'd1,
    OP_LO   = 2'd2,
    OP_BAD  = 2'd3
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [4:0] rd;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [4:0] rc;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2
  } state_e;
endpackage

// File: rtl/fmadd_decode.sv
module fmadd_decode
  import fmadd_pkg::*;
(
  input  logic [31:0] insn,
  output dec_t        dec
);
  always_comb begin
    dec.rd = insn[25:21];
    dec.ra = insn[20:16];
    dec.rb = insn[15:11];
    dec.rc = insn[10:6];
    dec.op = OP_BAD;
    if (insn[31:26] == PRIMARY_OP) begin
      if (insn[5:1] == XO_HIGH)
        dec.op = insn[0] ? OP_HI_U : OP_HI_S;
      else if (insn[5:1] == XO_LOW)
        dec.op = OP_LO;
    end
  end
endmodule

// File: rtl/fmadd_core.sv
module fmadd_core #(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                step,
  input  logic                signed_mul,
  input  logic [XLEN-1:0]     a,
  input  logic [XLEN-1:0]     b,
  input  logic [XLEN-1:0]     c,
  output logic [2*XLEN-1:0]   acc
);
  localparam int AW = 2 * XLEN;

  logic [AW-1:0]   a_sh;
  logic [XLEN-1:0] b_rem;
  logic [AW-1:0]   c_ext, corr_a, corr_b, partial;

  // Signed product = unsigned product minus the weight of each sign bit.
  assign c_ext  = signed_mul ? {{XLEN{c[XLEN-1]}}, c} : {{XLEN{1'b0}}, c};
  assign corr_a = (signed_mul && a[XLEN-1]) ? {b, {XLEN{1'b0}}} : '0;
  assign corr_b = (signed_mul && b[XLEN-1]) ? {a, {XLEN{1'b0}}} : '0;

  // One chunk of B per cycle against the progressively shifted A.
  assign partial = a_sh * AW'(b_rem[STEP_BITS-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      a_sh  <= '0;
      b_rem <= '0;
    end else if (load) begin
      acc   <= c_ext - corr_a - corr_b;
      a_sh  <= AW'(a);
      b_rem <= b;
    end else if (step) begin
      acc   <= acc + partial;
      a_sh  <= a_sh << STEP_BITS;
      b_rem <= b_rem >> STEP_BITS;
    end
  end
endmodule

// File: rtl/fmadd_dw_unit.sv
module fmadd_dw_unit
  import fmadd_pkg::*;
#(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [31:0]     in_insn,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  input  logic [XLEN-1:0] in_c,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_result,
  output logic            out_illegal,
  output logic [4:0]      out_rd,
  output logic [4:0]      out_ra,
  output logic [4:0]      out_rb,
  output logic [4:0]      out_rc
);
  localparam int STEPS = XLEN / STEP_BITS;
  localparam int CW    = (STEPS > 1) ? $clog2(STEPS) : 1;

  state_e            state;
  logic [CW-1:0]     cnt;
  dec_t              dec, dec_r;
  logic              accept, legal;
  logic [2*XLEN-1:0] acc;

  fmadd_decode u_dec (.insn(in_insn), .dec(dec));

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign legal    = (dec.op != OP_BAD);

  fmadd_core #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept && legal),
    .step       (state == ST_BUSY),
    .signed_mul (dec.op == OP_HI_S),
    .a          (in_a),
    .b          (in_b),
    .c          (in_c),
    .acc        (acc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      dec_r <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          dec_r <= dec;
          cnt   <= '0;
          state <= legal ? ST_BUSY : ST_DONE;
        end
        ST_BUSY: begin
          if (cnt == CW'(STEPS - 1)) state <= ST_DONE;
          else                       cnt   <= cnt + 1'b1;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid   = (state == ST_DONE);
  assign out_illegal = (dec_r.op == OP_BAD);
  assign out_rd      = dec_r.rd;
  assign out_ra      = dec_r.ra;
  assign out_rb      = dec_r.rb;
  assign out_rc      = dec_r.rc;

  always_comb begin
    unique case (dec_r.op)
      OP_LO:   out_result = acc[XLEN-1:0];
      OP_BAD:  out_result = '0;
      default: out_result = acc[2*XLEN-1:XLEN];
    endcase
  end
endmodule

// File: rtl/fmadd_dw_chk.sv
module fmadd_dw_chk #(
  parameter int XLEN      = 64,
  parameter int STEP_BITS = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_result,
  input logic            out_illegal,
  input logic [4:0]      out_rd
);
  localparam int STEPS = XLEN / STEP_BITS;

  int unsigned lat;
  always_ff @(posedge clk) begin
    if (!rst_n)                   lat <= 0;
    else if (in_valid && in_ready) lat <= 1;
    else if (!out_valid)           lat <= lat + 1;
  end

  // R8
  ready_valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R8
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> !in_ready);
  // R6
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> out_result == '0);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
                                $stable(out_illegal) && $stable(out_rd));
  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid && in_ready);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_illegal ? lat == 1 : lat == STEPS + 1));
endmodule

bind fmadd_dw_unit fmadd_dw_chk #(.XLEN(XLEN), .STEP_BITS(STEP_BITS)) u_chk (.*);

// File: tb/test_fmadd_dw_unit.sv
`timescale 1ns/1ps
module test_fmadd_dw_unit;
  localparam int XLEN  = 64;
  localparam int STEP  = 8;
  localparam int STEPS = XLEN / STEP;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1, out_illegal;
  logic [31:0] in_insn = '0;
  logic [63:0] in_a = '0, in_b = '0, in_c = '0, out_result;
  logic [4:0]  out_rd, out_ra, out_rb, out_rc;

  always #2.5 clk = ~clk;

  fmadd_dw_unit #(.XLEN(XLEN), .STEP_BITS(STEP)) i_fmadd_dw_unit (.*);

  int total = 0, bad = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [5:0] prim, logic [4:0] xo, logic u,
                                     logic [4:0] rd, logic [4:0] ra,
                                     logic [4:0] rb, logic [4:0] rc);
    return {prim, rd, ra, rb, rc, xo, u};
  endfunction

  // Behavioural reference: 128-bit arithmetic per the requirements.
  function automatic void ref_calc(logic [31:0] w, logic [63:0] a, logic [63:0] b,
                                   logic [63:0] c, output logic ill,
                                   output logic [63:0] res);
    logic [127:0] s;
    ill = 0; res = '0;
    if (w[31:26] != 6'd4 || (w[5:1] != 5'h18 && w[5:1] != 5'h19)) begin
      ill = 1;
    end else if (w[5:1] == 5'h19) begin
      res = a * b + c;
    end else if (w[0]) begin
      s = {64'd0, a} * {64'd0, b} + {64'd0, c};
      res = s[127:64];
    end else begin
      s = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b}) + $signed({{64{c[63]}}, c});
      res = s[127:64];
    end
  endfunction

  // Cycle model: 0 idle, 1 busy, 2 holding a response.
  int m_state = 0, m_cnt = 0;
  logic m_ill; logic [63:0] m_res; logic [19:0] m_regs;
  string m_tag = "R2", nxt_tag = "R2";

  always @(negedge clk) begin
    if (!rst_n) m_state = 0;
    else begin
      chk("R8 in_ready", in_ready, m_state == 0);
      chk("R9 out_valid", out_valid, m_state == 2);
      if (m_state == 2 && out_valid) begin
        chk(m_tag, out_result, m_res);
        chk("R6 illegal", out_illegal, m_ill);
        chk("R7 regs", {out_rd, out_ra, out_rb, out_rc}, m_regs);
        if (!out_ready) chk("R10 held", out_result, m_res);
      end
      case (m_state)
        0: if (in_valid) begin
          ref_calc(in_insn, in_a, in_b, in_c, m_ill, m_res);
          m_regs = in_insn[25:6];
          m_tag  = nxt_tag;
          if (m_ill) m_state = 2; else begin m_state = 1; m_cnt = STEPS; end
        end
        1: begin m_cnt--; if (m_cnt == 0) m_state = 2; end
        default: if (out_ready) m_state = 0;
      endcase
    end
  end

  // Back-pressure driver.
  bit bp_on = 0;
  logic [15:0] lfsr = 16'hACE1;
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_on ? lfsr[0] : 1'b1;
  end

  task automatic issue(string tag, logic [31:0] w, logic [63:0] a,
                       logic [63:0] b, logic [63:0] c);
    bit took;
    nxt_tag = tag;
    in_valid = 1; in_insn = w; in_a = a; in_b = b; in_c = c;
    do begin
      took = in_ready;
      @(posedge clk); #1;
    end while (!took);
    in_valid = 0;
  endtask

  localparam logic [63:0] MINV = 64'h8000_0000_0000_0000;
  localparam logic [63:0] ONES = '1;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 in_ready", in_ready, 1);
    chk("R11 out_valid", out_valid, 0);
    @(posedge clk); #1; rst_n = 1;

    issue("R2", mk(4, 5'h18, 0, 3, 4, 5, 6), 64'd123456789, -64'sd987654321, 64'd55);
    issue("R3", mk(4, 5'h18, 1, 7, 8, 9, 10), 64'hDEAD_BEEF_1234_5678, 64'hFEED_FACE_CAFE_0001, ONES);
    issue("R4", mk(4, 5'h19, 0, 1, 2, 3, 4), 64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321, 64'h77);
    issue("R1 low ignores bit0", mk(4, 5'h19, 1, 11, 12, 13, 14), ONES, 64'd3, 64'd5);
    issue("R5 min*min", mk(4, 5'h18, 0, 1, 1, 1, 1), MINV, MINV, 64'd0);
    issue("R5 ones signed", mk(4, 5'h18, 0, 2, 2, 2, 2), ONES, ONES, 64'd0);
    issue("R5 ones unsigned", mk(4, 5'h18, 1, 2, 2, 2, 2), ONES, ONES, ONES);
    issue("R5 carry", mk(4, 5'h18, 1, 3, 3, 3, 3), 64'd1, ONES, 64'd1);
    issue("R5 borrow", mk(4, 5'h18, 0, 4, 4, 4, 4), 64'd0, 64'd9, ONES);
    issue("R3 zero-ext", mk(4, 5'h18, 1, 4, 4, 4, 4), 64'd0, 64'd9, ONES);
    issue("R6 bad primary", mk(5, 5'h18, 0, 9, 9, 9, 9), 64'd3, 64'd3, 64'd3);
    issue("R6 bad ext", mk(4, 5'h1A, 0, 8, 8, 8, 8), 64'd3, 64'd3, 64'd3);
    bp_on = 1;
    for (int i = 0; i < 40; i++) begin
      logic [4:0] xo;
      xo = (i % 7 == 6) ? 5'h03 : ((i % 3 == 2) ? 5'h19 : 5'h18);
      issue("R2/R3/R4 random", mk(4, xo, i[0], 5'(i), 5'(i + 1), 5'(i + 2), 5'(i + 3)),
            {$urandom, $urandom}, {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (3 * STEPS) @(posedge clk);
    bp_on = 0;
    repeat (4) @(posedge clk);
    finished = 1;
  end

  initial begin
    while (!finished && cycles < 20000) begin
      @(posedge clk); cycles++;
    end
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=finish", cycles);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule